// File: doc/BRIEF.md
# SDRAM Host Command Front End

This block sits between a host and the command sequencer of a single-data-rate SDRAM controller. The host drives a 3-bit command code and an address. The block samples them on a rising clock edge, answers each accepted command with a one-cycle acknowledge, and either forwards the command to the downstream sequencer or handles it locally.

Two commands are handled locally. The first loads a packed timing register from the address bus. The second loads a 16-bit refresh period. The block also runs a refresh down-counter from the period. When the counter expires, it injects refresh requests into the downstream request stream without any host involvement. An injected refresh takes priority over a waiting host command. Nothing is issued while the sequencer reports busy.

Top module: `sdr_host_ctrl`

## Requirements
- R1: While reset is high and on leaving it, `host_ack` and `req_valid` are 0. The timing fields read cas 3, rcd 3, ref_cycles 10, page 0 and burst 8. `cfg_period` is 0.
- R2: Command codes are 001 read, 010 write, 011 refresh, 100 precharge all, 101 mode load. When one of these is accepted at an edge, the next cycle shows `req_valid`=1 for one cycle, with `req_kind` equal to the code, `req_addr` equal to the sampled address, and `req_auto`=0.
- R3: `host_ack` rises in the cycle after the accepting edge and lasts exactly one cycle. A command still driven during the acknowledge cycle is not accepted a second time.
- R4: Code 000 produces neither an acknowledge nor a request.
- R5: Code 110 loads the timing register from the address: cas [1:0], rcd [3:2], ref_cycles [7:4], page [8], burst [12:9]. The load is acknowledged, no request is forwarded, and the new fields appear in the acknowledge cycle.
- R6: Code 111 loads `cfg_period` from address bits [15:0]. The load is acknowledged and no request is forwarded.
- R7: With a nonzero period P and the sequencer idle, an automatic refresh is issued P edges after the period load and then every P edges. It shows as `req_valid`=1, `req_auto`=1, `req_kind`=011 and `req_addr`=0, with no acknowledge.
- R8: While the period is 0, no automatic refresh is issued.
- R9: If an automatic refresh is due at the same edge that a host command is presented, the refresh is issued first. The host command is accepted and acknowledged at the following edge.
- R10: While `seq_busy` is 1, no host command is accepted and no automatic refresh is issued. A refresh that falls due meanwhile is issued at the first edge with `seq_busy` at 0.
- R11: Every issued refresh, host or automatic, restarts the period count. The next automatic refresh then comes P edges after that refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cmd | input | 3 | Host command code |
| host_addr | input | ADDR_W | Host address / load value |
| seq_busy | input | 1 | Downstream sequencer busy |
| host_ack | output | 1 | One-cycle command acknowledge |
| req_valid | output | 1 | Downstream request strobe |
| req_kind | output | 3 | Downstream request code |
| req_auto | output | 1 | Request is an internal refresh |
| req_addr | output | ADDR_W | Downstream request address |
| cfg_cas | output | 2 | CAS latency setting |
| cfg_rcd | output | 2 | Row-to-column delay |
| cfg_ref_cycles | output | 4 | Refresh command duration |
| cfg_page | output | 1 | Page mode enable |
| cfg_burst | output | 4 | Burst length |
| cfg_period | output | 16 | Refresh interval in cycles |

## Verification
A refresh counter that is wrong by one shows up at the ports as a refresh pulse one cycle early or late. That error is visible P cycles after the load, or after any host refresh. A stuck pending flag either repeats refresh pulses on every edge or starves host commands, so the expected acknowledge fails to appear within one cycle. Misplaced register fields show on the configuration outputs in the acknowledge cycle itself. A broken acknowledge guard shows as a second request in the cycle after a held command.

// File: rtl/sdr_host_pkg.sv
package sdr_host_pkg;

  typedef enum logic [2:0] {
    HC_IDLE   = 3'b000,
    HC_RD     = 3'b001,
    HC_WR     = 3'b010,
    HC_REF    = 3'b011,
    HC_PREALL = 3'b100,
    HC_MODE   = 3'b101,
    HC_CFG    = 3'b110,
    HC_PERIOD = 3'b111
  } host_cmd_e;

  // Member order gives the packed bit positions [12:0] of the load value.
  typedef struct packed {
    logic [3:0] burst;      // [12:9]
    logic       page;       // [8]
    logic [3:0] ref_cycles; // [7:4]
    logic [1:0] rcd;        // [3:2]
    logic [1:0] cas;        // [1:0]
  } timing_cfg_t;

  localparam int CFG_W = $bits(timing_cfg_t);

  localparam timing_cfg_t CFG_SAFE = '{
    burst: 4'd8, page: 1'b0, ref_cycles: 4'd10, rcd: 2'd3, cas: 2'd3
  };

endpackage

// File: rtl/shc_cfg_regs.sv
module shc_cfg_regs
  import sdr_host_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_timing,
  input  logic                ld_period,
  input  logic [CFG_W-1:0]    timing_val,
  input  logic [PERIOD_W-1:0] period_val,
  output timing_cfg_t         timing_q,
  output logic [PERIOD_W-1:0] period_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      timing_q <= CFG_SAFE;
      period_q <= '0;
    end else begin
      if (ld_timing) timing_q <= timing_cfg_t'(timing_val);
      if (ld_period) period_q <= period_val;
    end
  end

endmodule

// File: rtl/shc_refresh_timer.sv
module shc_refresh_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] period,
  input  logic                ld_period,
  input  logic [PERIOD_W-1:0] period_val,
  input  logic                refresh_launch,
  output logic                due
);

  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ld_period) begin
      cnt <= (period_val == '0) ? '0 : period_val - ONE;
    end else if (refresh_launch) begin
      cnt <= (period == '0) ? '0 : period - ONE;
    end else if (period != '0 && cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  assign due = (period != '0) && (cnt == '0);

  // A due refresh stays pending until it is launched or the period is rewritten.
  assert_due_held_R10: assert property (@(posedge clk) disable iff (rst)
    (due && !refresh_launch && !ld_period) |=> due);

  // Any launched refresh restarts the interval.
  assert_reload_R11: assert property (@(posedge clk) disable iff (rst)
    (refresh_launch && !ld_period && period > ONE) |=> !due);

  // With the period at zero the timer never requests.
  assert_off_when_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (ld_period && period_val == '0) |=> !due);

endmodule

// File: rtl/shc_cmd_issue.sv
module shc_cmd_issue
  import sdr_host_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        host_cmd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              seq_busy,
  input  logic              due,
  output logic              host_ack,
  output logic              req_valid,
  output logic [2:0]        req_kind,
  output logic              req_auto,
  output logic [ADDR_W-1:0] req_addr,
  output logic              ld_timing,
  output logic              ld_period,
  output logic              refresh_launch
);

  host_cmd_e cmd_e;
  logic      auto_go;
  logic      host_go;
  logic      fwd;

  always_comb begin
    cmd_e          = host_cmd_e'(host_cmd);
    auto_go        = due && !seq_busy;
    host_go        = (cmd_e != HC_IDLE) && !seq_busy && !due && !host_ack;
    ld_timing      = host_go && (cmd_e == HC_CFG);
    ld_period      = host_go && (cmd_e == HC_PERIOD);
    fwd            = host_go && !ld_timing && !ld_period;
    refresh_launch = auto_go || (host_go && cmd_e == HC_REF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_ack  <= 1'b0;
      req_valid <= 1'b0;
      req_auto  <= 1'b0;
      req_kind  <= HC_IDLE;
      req_addr  <= '0;
    end else begin
      host_ack  <= host_go;
      req_valid <= auto_go || fwd;
      req_auto  <= auto_go;
      req_kind  <= auto_go ? HC_REF : (fwd ? host_cmd : HC_IDLE);
      req_addr  <= fwd ? host_addr : '0;
    end
  end

  assert_ack_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);

  assert_no_ack_when_busy_R10: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> !$past(seq_busy));

  assert_refresh_first_R9: assert property (@(posedge clk) disable iff (rst)
    (due && !seq_busy) |=> (req_valid && req_auto));

  assert_host_req_acked_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_auto) |-> host_ack);

  assert_auto_is_refresh_R7: assert property (@(posedge clk) disable iff (rst)
    req_auto |-> (req_valid && req_kind == 3'b011 && !host_ack));

endmodule

// File: rtl/sdr_host_ctrl.sv
module sdr_host_ctrl
  import sdr_host_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          host_cmd,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic                seq_busy,
  output logic                host_ack,
  output logic                req_valid,
  output logic [2:0]          req_kind,
  output logic                req_auto,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [1:0]          cfg_cas,
  output logic [1:0]          cfg_rcd,
  output logic [3:0]          cfg_ref_cycles,
  output logic                cfg_page,
  output logic [3:0]          cfg_burst,
  output logic [PERIOD_W-1:0] cfg_period
);

  logic        ld_timing;
  logic        ld_period;
  logic        refresh_launch;
  logic        due;
  timing_cfg_t timing_q;

  shc_cmd_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk            (clk),
    .rst            (rst),
    .host_cmd       (host_cmd),
    .host_addr      (host_addr),
    .seq_busy       (seq_busy),
    .due            (due),
    .host_ack       (host_ack),
    .req_valid      (req_valid),
    .req_kind       (req_kind),
    .req_auto       (req_auto),
    .req_addr       (req_addr),
    .ld_timing      (ld_timing),
    .ld_period      (ld_period),
    .refresh_launch (refresh_launch)
  );

  shc_cfg_regs #(.PERIOD_W(PERIOD_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .ld_timing  (ld_timing),
    .ld_period  (ld_period),
    .timing_val (host_addr[CFG_W-1:0]),
    .period_val (host_addr[PERIOD_W-1:0]),
    .timing_q   (timing_q),
    .period_q   (cfg_period)
  );

  shc_refresh_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk            (clk),
    .rst            (rst),
    .period         (cfg_period),
    .ld_period      (ld_period),
    .period_val     (host_addr[PERIOD_W-1:0]),
    .refresh_launch (refresh_launch),
    .due            (due)
  );

  assign cfg_cas        = timing_q.cas;
  assign cfg_rcd        = timing_q.rcd;
  assign cfg_ref_cycles = timing_q.ref_cycles;
  assign cfg_page       = timing_q.page;
  assign cfg_burst      = timing_q.burst;

endmodule

// File: tb/sdr_host_ctrl_test.sv
`timescale 1ns/1ps
module sdr_host_ctrl_test;

  localparam int ADDR_W = 22;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        host_cmd = 3'd0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic              seq_busy = 1'b0;
  logic              host_ack, req_valid, req_auto, cfg_page;
  logic [2:0]        req_kind;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        cfg_cas, cfg_rcd;
  logic [3:0]        cfg_ref_cycles, cfg_burst;
  logic [15:0]       cfg_period;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sdr_host_ctrl #(.ADDR_W(ADDR_W), .PERIOD_W(16)) uut (
    .clk(clk), .rst(rst), .host_cmd(host_cmd), .host_addr(host_addr),
    .seq_busy(seq_busy), .host_ack(host_ack), .req_valid(req_valid),
    .req_kind(req_kind), .req_auto(req_auto), .req_addr(req_addr),
    .cfg_cas(cfg_cas), .cfg_rcd(cfg_rcd), .cfg_ref_cycles(cfg_ref_cycles),
    .cfg_page(cfg_page), .cfg_burst(cfg_burst), .cfg_period(cfg_period)
  );

  // Entry: {code[2:0], addr[15:0], expect_ack, expect_req}
  localparam logic [20:0] VEC [8] = '{
    {3'b000, 16'h1111, 1'b0, 1'b0},  // R4 idle code
    {3'b001, 16'h0100, 1'b1, 1'b1},  // R2 read
    {3'b010, 16'h0203, 1'b1, 1'b1},  // R2 write
    {3'b011, 16'h0042, 1'b1, 1'b1},  // R2 host refresh
    {3'b100, 16'h0400, 1'b1, 1'b1},  // R2 precharge all
    {3'b101, 16'h0032, 1'b1, 1'b1},  // R2 mode load
    {3'b110, 16'h1234, 1'b1, 1'b0},  // R5 timing load, local
    {3'b111, 16'h0000, 1'b1, 1'b0}   // R6 period load, local
  };

  task automatic neg();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic [15:0] a);
    host_cmd  = c;
    host_addr = {6'd0, a};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) neg();
    // R1 reset state
    chk("R1 ack", host_ack, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 cas", cfg_cas, 3);
    chk("R1 rcd", cfg_rcd, 3);
    chk("R1 ref_cycles", cfg_ref_cycles, 10);
    chk("R1 page", cfg_page, 0);
    chk("R1 burst", cfg_burst, 8);
    chk("R1 period", cfg_period, 0);
    rst = 1'b0;
    neg();
    chk("R1 no request after reset", req_valid, 0);

    // Vector walk: R2 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      logic [2:0]  c;
      logic [15:0] a;
      c = VEC[i][20:18];
      a = VEC[i][17:2];
      drive(c, a);
      neg();
      chk($sformatf("R2 R4 vec%0d ack", i), host_ack, VEC[i][1]);
      chk($sformatf("R2 R4 vec%0d req", i), req_valid, VEC[i][0]);
      if (VEC[i][0]) begin
        chk($sformatf("R2 vec%0d kind", i), req_kind, c);
        chk($sformatf("R2 vec%0d addr", i), req_addr, a);
        chk($sformatf("R2 vec%0d auto", i), req_auto, 0);
      end
      drive(3'b000, 16'h0);
      neg();
      chk($sformatf("R3 vec%0d ack drop", i), host_ack, 0);
      chk($sformatf("R3 vec%0d req drop", i), req_valid, 0);
    end

    // R3 command held through the acknowledge cycle
    drive(3'b001, 16'h0155);
    neg();
    chk("R3 held ack", host_ack, 1);
    neg();
    chk("R3 held no reaccept ack", host_ack, 0);
    chk("R3 held no reaccept req", req_valid, 0);
    drive(3'b000, 16'h0);

    // R5 timing register field positions
    neg();
    drive(3'b110, 16'd2410); // burst 4, page 1, ref 6, rcd 2, cas 2
    neg();
    chk("R5 ack", host_ack, 1);
    chk("R5 no req", req_valid, 0);
    chk("R5 cas", cfg_cas, 2);
    chk("R5 rcd", cfg_rcd, 2);
    chk("R5 ref_cycles", cfg_ref_cycles, 6);
    chk("R5 page", cfg_page, 1);
    chk("R5 burst", cfg_burst, 4);
    drive(3'b000, 16'h0);

    // R7 periodic automatic refresh, P = 5
    neg();
    drive(3'b111, 16'd5);
    for (int k = 1; k <= 12; k++) begin
      neg();
      if (k == 1) begin
        chk("R6 period value", cfg_period, 5);
        drive(3'b000, 16'h0);
      end
      chk($sformatf("R7 auto pulse k=%0d", k), req_valid && req_auto, (k == 6 || k == 11));
      if (k == 6) begin
        chk("R7 auto kind", req_kind, 3);
        chk("R7 auto addr", req_addr, 0);
        chk("R7 auto no ack", host_ack, 0);
      end
    end

    // R9 priority of a due refresh over a host read
    repeat (3) neg();
    drive(3'b001, 16'h00AB);
    neg();
    chk("R9 refresh first", req_valid && req_auto, 1);
    chk("R9 host held", host_ack, 0);
    neg();
    chk("R9 host ack next", host_ack, 1);
    chk("R9 host kind", req_kind, 1);
    chk("R9 host not auto", req_auto, 0);
    chk("R9 host addr", req_addr, 16'h00AB);
    drive(3'b000, 16'h0);

    // R8 period zero disables refresh
    neg();
    drive(3'b111, 16'd0);
    neg();
    drive(3'b000, 16'h0);
    for (int k = 0; k < 20; k++) begin
      neg();
      chk("R8 no refresh when disabled", req_valid, 0);
    end

    // R11 host refresh restarts the interval, P = 8
    drive(3'b111, 16'd8);
    neg();
    drive(3'b000, 16'h0);
    repeat (3) neg();
    drive(3'b011, 16'h0);
    neg();
    chk("R11 host refresh ack", host_ack, 1);
    chk("R11 host refresh kind", req_kind, 3);
    chk("R11 host refresh not auto", req_auto, 0);
    drive(3'b000, 16'h0);
    for (int k = 6; k <= 14; k++) begin
      neg();
      chk($sformatf("R11 auto pulse k=%0d", k), req_valid && req_auto, (k == 13));
    end

    // R10 busy holds host command and due refresh, P = 3
    neg();
    drive(3'b111, 16'd3);
    neg();
    drive(3'b010, 16'h002C);
    seq_busy = 1'b1;
    for (int k = 2; k <= 6; k++) begin
      neg();
      chk($sformatf("R10 busy no req k=%0d", k), req_valid, 0);
      chk($sformatf("R10 busy no ack k=%0d", k), host_ack, 0);
    end
    seq_busy = 1'b0;
    neg();
    chk("R10 released refresh", req_valid && req_auto, 1);
    chk("R10 released no ack", host_ack, 0);
    neg();
    chk("R10 host write ack", host_ack, 1);
    chk("R10 host write kind", req_kind, 2);
    chk("R10 host write addr", req_addr, 16'h002C);
    drive(3'b000, 16'h0);
    neg();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule